// File: doc/BRIEF.md
# I2C Slave Controller with Receive and Transmit Queues

This block is a bus target for a two-wire serial bus. It watches the clock and data lines and recognises its own 7-bit address. Bytes that a master writes go into a 16-entry receive queue. Bytes that a master reads come from a 16-entry transmit queue. Both lines are open-drain: the block has only active-low pull-down enables, and the incoming lines pass through two-flop synchronizers.

Software sees the block through a small register port. Through it, software:

- loads the transmit queue and drains the receive queue;
- sets the slave address and a receive-level threshold;
- handles a sticky event register, whose bits are cleared by writing a 1.

An interrupt line is driven by the OR of the enabled event bits. Each transfer is framed by two events: an "addressed" event at the address match, and an "ended" event when a stop or a repeated start closes the transfer. When the master wants data and the transmit queue is empty, the block holds the clock low until software writes a byte.

The bit engine is a state machine with these states:

- IDLE: waits for a start condition.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the acknowledge for the address.
- RX_BITS and RX_ACK: receive a byte and acknowledge it.
- TX_LOAD: fetches the next byte, stretching the clock while the queue is empty.
- TX_BITS: shifts a byte out.
- TX_ACK: samples the master's acknowledge.
- WAIT_END: waits out a transfer that is not for this block, or one the master has refused.

Its transitions are:

- A start condition from any state goes to ADDR.
- A stop condition from any state goes to IDLE.
- In ADDR, the eighth clock fall goes to ADDR_ACK on a match and to WAIT_END on a mismatch.
- From ADDR_ACK, the next clock fall goes to TX_LOAD for a read and to RX_BITS for a write.
- The eighth clock fall of a received byte goes from RX_BITS to RX_ACK; the next fall goes back to RX_BITS.
- TX_LOAD goes to TX_BITS as soon as the transmit queue holds a byte.
- The eighth clock fall in TX_BITS goes to TX_ACK.
- From TX_ACK, the next clock fall goes to TX_LOAD if the master acknowledged and to WAIT_END if it did not.

Top module: `i2c_slave_fifo`

## Requirements
- R1: While reset is asserted, the event register reads 0, the interrupt output is low, both drive enables are 1 (released), and the occupancy register reads 0x10.
- R2: An address byte whose upper seven bits equal the slave-address register (address 3) is acknowledged and sets event bit 0. An address byte that does not match is not acknowledged and sets neither bit 0 nor bit 1.
- R3: Each byte that a master writes is acknowledged while the receive queue has room. Reads of address 5 return the bytes in arrival order and remove them from the queue.
- R4: With threshold register value N (address 2, 4 bits), event bit 2 is set once the receive queue holds N+1 or more bytes, and never before.
- R5: The occupancy register (address 6) reads, in bits 3:0, the byte count minus one, with bit 4 at 0 while the queue holds 1 to 16 bytes. When the queue is empty it reads exactly 0x10.
- R6: A byte written while the receive queue already holds 16 bytes is not acknowledged and not stored, and it sets event bit 3.
- R7: Event bit 1 is set when a stop or a repeated start ends a transfer that matched the address. This holds even when no data byte was moved.
- R8: On a read transfer, the bytes written to address 4 are sent in write order, most significant bit first.
- R9: When a byte must be sent and the transmit queue is empty, the clock line is held low until a byte is written to address 4.
- R10: A master that does not acknowledge a sent byte sets event bit 6.
- R11: Event bit 4 is set while the transmit queue is empty. Event bit 5 is set while it holds 8 or fewer bytes.
- R12: Writing address 0 clears the event bits written with 1, unless their set condition is still present. The interrupt output is the OR of the event bits ANDed with the enable register (address 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_drv_n | output | 1 | Clock pull-down enable, 0 pulls the line low |
| sda_drv_n | output | 1 | Data pull-down enable, 0 pulls the line low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive queue at address 5) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Interrupt, registered OR of enabled event bits |

## Verification
The receive path is swept over all 16 threshold values, with 16 bytes per transfer. After every byte, the bench compares the level bit and the occupancy against the arithmetic N+1 rule, so an off-by-one in either the threshold or the count encoding stands out. It then overfills the queue once to separate storing from refusing.

Transfers are also run with:

- a foreign address;
- no data bytes;
- a repeated start in place of a stop.

Together these separate the framing events from one another. Read transfers compare a multi-byte ordered stream that ends in a master refusal with a transfer that starts on an empty queue, which shows whether the clock is really held until software supplies a byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX_BITS, ST_RX_ACK,
        ST_TX_LOAD, ST_TX_BITS, ST_TX_ACK, ST_WAIT_END
    } eng_state_t;

    localparam int NEV = 7;
    localparam logic [2:0] RA_EVENT  = 3'd0;
    localparam logic [2:0] RA_ENABLE = 3'd1;
    localparam logic [2:0] RA_THRESH = 3'd2;
    localparam logic [2:0] RA_MYADDR = 3'd3;
    localparam logic [2:0] RA_TXPUT  = 3'd4;
    localparam logic [2:0] RA_RXGET  = 3'd5;
    localparam logic [2:0] RA_RXOCC  = 3'd6;

    localparam int EB_ADDR   = 0;
    localparam int EB_END    = 1;
    localparam int EB_RXLVL  = 2;
    localparam int EB_RXOVF  = 3;
    localparam int EB_TXEMP  = 4;
    localparam int EB_TXHALF = 5;
    localparam int EB_TXDONE = 6;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R6: a push into a full queue leaves the count alone
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));
    // R3: occupancy never exceeds the depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R3: popping an empty queue does not underflow
    a_r3_pop_empty_safe: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic [6:0] own_addr,
    input  logic       tx_empty,
    input  logic [7:0] tx_data,
    input  logic       rx_full,
    output logic       tx_pop,
    output logic       rx_push,
    output logic [7:0] rx_data,
    output logic       ev_addr,
    output logic       ev_end,
    output logic       ev_ovf,
    output logic       ev_txdone,
    output logic       scl_drv_n,
    output logic       sda_drv_n
);
    eng_state_t state;
    logic       scl_q, sda_q, active, ack_ok;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       scl_rise, scl_fall, bus_start, bus_stop, byte_end, hit;

    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign bus_start = scl_s && scl_q && sda_q && !sda_s;
    assign bus_stop  = scl_s && scl_q && !sda_q && sda_s;
    assign byte_end  = scl_fall && (bitcnt == 4'd8);
    assign hit       = (shreg[7:1] == own_addr);
    assign rx_data   = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            shreg  <= '0;
            bitcnt <= '0;
            active <= 1'b0;
            ack_ok <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            if (bus_start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                active <= 1'b0;
            end else if (bus_stop) begin
                state  <= ST_IDLE;
                active <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT_END: ;
                    ST_ADDR, ST_RX_BITS: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            if (state == ST_RX_BITS) begin
                                ack_ok <= !rx_full;
                                state  <= ST_RX_ACK;
                            end else if (hit) begin
                                active <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_WAIT_END;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        state  <= shreg[0] ? ST_TX_LOAD : ST_RX_BITS;
                    end
                    ST_RX_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        state  <= ST_RX_BITS;
                    end
                    ST_TX_LOAD: if (!tx_empty) begin
                        shreg  <= tx_data;
                        bitcnt <= '0;
                        state  <= ST_TX_BITS;
                    end
                    ST_TX_BITS: if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) state <= ST_TX_ACK;
                    end
                    ST_TX_ACK: begin
                        if (scl_rise)      ack_ok <= !sda_s;
                        else if (scl_fall) state  <= ack_ok ? ST_TX_LOAD : ST_WAIT_END;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sda_drv_n = 1'b1;
        scl_drv_n = 1'b1;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        ev_addr   = 1'b0;
        ev_ovf    = 1'b0;
        ev_txdone = 1'b0;
        ev_end    = (bus_start || bus_stop) && active;
        unique case (state)
            ST_ADDR:     ev_addr = byte_end && hit;
            ST_ADDR_ACK: sda_drv_n = 1'b0;
            ST_RX_BITS: begin
                rx_push = byte_end && !rx_full;
                ev_ovf  = byte_end && rx_full;
            end
            ST_RX_ACK:   sda_drv_n = !ack_ok;
            ST_TX_LOAD: begin
                scl_drv_n = !tx_empty;
                tx_pop    = !tx_empty;
            end
            ST_TX_BITS:  sda_drv_n = shreg[7];
            ST_TX_ACK:   ev_txdone = scl_fall && !ack_ok;
            default: ;
        endcase
    end

    // R9: the clock is only ever held low for lack of transmit data
    a_r9_stretch_needs_empty: assert property (@(posedge clk) disable iff (rst)
        !scl_drv_n |-> tx_empty);
endmodule

// File: rtl/i2c_slave_fifo.sv
module i2c_slave_fifo
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_drv_n,
    output logic       sda_drv_n,
    input  logic       reg_we,
    input  logic       reg_re,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic           scl_s, sda_s;
    logic [6:0]     own_addr;
    logic [AW-1:0]  thresh;
    logic [NEV-1:0] events, enables, set_vec, clr_vec;
    logic [7:0]     rx_wdata, rx_head, tx_head;
    logic [CW-1:0]  rx_count, tx_count;
    logic           rx_full, rx_empty, tx_full, tx_empty;
    logic           rx_push, tx_pop, ev_addr, ev_end, ev_ovf, ev_txdone;
    logic [7:0]     occ;
    logic [CW-1:0]  rx_cnt_m1;

    i2cs_sync u_scl_sync (.clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
    i2cs_sync u_sda_sync (.clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

    i2cs_engine u_engine (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .own_addr(own_addr),
        .tx_empty(tx_empty), .tx_data(tx_head), .rx_full(rx_full),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_wdata),
        .ev_addr(ev_addr), .ev_end(ev_end), .ev_ovf(ev_ovf), .ev_txdone(ev_txdone),
        .scl_drv_n(scl_drv_n), .sda_drv_n(sda_drv_n)
    );

    i2cs_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_wdata),
        .pop(reg_re && reg_addr == RA_RXGET), .rdata(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    i2cs_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(reg_we && reg_addr == RA_TXPUT && !tx_full),
        .wdata(reg_wdata), .pop(tx_pop), .rdata(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[EB_ADDR]   = ev_addr;
        set_vec[EB_END]    = ev_end;
        set_vec[EB_RXLVL]  = rx_count > {1'b0, thresh};
        set_vec[EB_RXOVF]  = ev_ovf;
        set_vec[EB_TXEMP]  = tx_empty;
        set_vec[EB_TXHALF] = tx_count <= CW'(DEPTH / 2);
        set_vec[EB_TXDONE] = ev_txdone;
        clr_vec = (reg_we && reg_addr == RA_EVENT) ? reg_wdata[NEV-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            events   <= '0;
            enables  <= '0;
            thresh   <= '0;
            own_addr <= '0;
            irq      <= 1'b0;
        end else begin
            events <= (events & ~clr_vec) | set_vec;
            irq    <= |(events & enables);
            if (reg_we && reg_addr == RA_ENABLE) enables  <= reg_wdata[NEV-1:0];
            if (reg_we && reg_addr == RA_THRESH) thresh   <= reg_wdata[AW-1:0];
            if (reg_we && reg_addr == RA_MYADDR) own_addr <= reg_wdata[6:0];
        end
    end

    assign rx_cnt_m1 = rx_count - CW'(1);

    always_comb begin
        occ = '0;
        occ[AW] = rx_empty;
        if (!rx_empty) occ[AW-1:0] = rx_cnt_m1[AW-1:0];
    end

    always_comb begin
        unique case (reg_addr)
            RA_EVENT:  reg_rdata = 8'(events);
            RA_ENABLE: reg_rdata = 8'(enables);
            RA_THRESH: reg_rdata = 8'(thresh);
            RA_MYADDR: reg_rdata = {1'b0, own_addr};
            RA_RXGET:  reg_rdata = rx_head;
            RA_RXOCC:  reg_rdata = occ;
            default:   reg_rdata = '0;
        endcase
    end

    // R12: bits written with 1 are gone next cycle unless set again in that cycle
    a_r12_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_EVENT) |=>
        ((events & $past(reg_wdata[NEV-1:0]) & ~$past(set_vec)) == '0));
    // R4: reaching the threshold always leaves the level bit set
    a_r4_level_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_count > {1'b0, thresh}) |=> events[EB_RXLVL]);
endmodule

// File: tb/tb_i2c_slave_fifo.sv
module tb_i2c_slave_fifo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line, scl_drv_n, sda_drv_n, irq;
    logic reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;

    assign scl_line = scl_m & scl_drv_n;
    assign sda_line = sda_m & sda_drv_n;

    i2c_slave_fifo dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drv_n(scl_drv_n), .sda_drv_n(sda_drv_n),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h2A;
    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = (a == 3'd5);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait (scl_line == 1'b1); tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; wait (scl_line == 1'b1); tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; wait (scl_line == 1'b1); tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait (scl_line == 1'b1); tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic nack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        put_bit(nack);
    endtask

    function automatic logic [7:0] pat(int n, int k);
        return 8'((n * 37 + k * 11) ^ 8'h5A);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d;
        logic ack;
        tick(4);
        // R1: reset state
        rd(3'd0, v); check("R1 events", v, 0);
        rd(3'd6, v); check("R1 occupancy", v, 8'h10);
        check("R1 irq", irq, 0);
        check("R1 scl release", scl_drv_n, 1);
        check("R1 sda release", sda_drv_n, 1);
        rst = 1'b0;
        tick(2);
        wr(3'd3, {1'b0, OWN});
        wr(3'd1, 8'h00);

        // R4/R5/R3/R6: threshold sweep with full-depth writes
        for (int n = 0; n < 16; n++) begin
            wr(3'd2, 8'(n));
            wr(3'd0, 8'h7F);
            bus_start();
            put_byte({OWN, 1'b0}, ack); check("R2 own address ack", ack, 1);
            for (int k = 1; k <= 16; k++) begin
                put_byte(pat(n, k), ack); check("R3 data ack", ack, 1);
                rd(3'd0, v); check("R4 level bit", v[2], (k >= n + 1) ? 1 : 0);
                rd(3'd6, v); check("R5 occupancy", v, k - 1);
            end
            if (n == 15) begin
                put_byte(8'hEE, ack); check("R6 overflow nack", ack, 0);
                rd(3'd0, v); check("R6 overflow bit", v[3], 1);
                rd(3'd6, v); check("R6 occupancy kept", v, 8'h0F);
            end
            bus_stop();
            rd(3'd0, v); check("R7 end and R2 addressed bits", v[1:0], 2'b11);
            for (int k = 1; k <= 16; k++) begin
                rd(3'd5, d); check("R3 order", d, pat(n, k));
            end
            rd(3'd6, v); check("R5 empty", v, 8'h10);
        end

        // R2/R7: foreign address
        wr(3'd0, 8'h7F);
        bus_start();
        put_byte({7'h2B, 1'b0}, ack); check("R2 foreign nack", ack, 0);
        bus_stop();
        rd(3'd0, v); check("R2 R7 no framing for foreign", v[1:0], 0);
        rd(3'd6, v); check("R2 nothing stored", v, 8'h10);

        // R7: zero-data transfer
        wr(3'd0, 8'h7F);
        bus_start();
        put_byte({OWN, 1'b0}, ack); check("R2 ack zero-data", ack, 1);
        bus_stop();
        rd(3'd0, v); check("R7 zero-data end", v[1:0], 2'b11);

        // R7: repeated start ends the transfer
        wr(3'd0, 8'h7F);
        bus_start();
        put_byte({OWN, 1'b0}, ack);
        put_byte(8'h99, ack); check("R3 ack before restart", ack, 1);
        bus_start();
        rd(3'd0, v); check("R7 repeated start end", v[1], 1);
        put_byte({7'h11, 1'b0}, ack); check("R2 foreign after restart", ack, 0);
        bus_stop();
        rd(3'd5, d); check("R3 byte before restart", d, 8'h99);

        // R11/R8/R10: read transfer
        for (int i = 0; i < 8; i++) wr(3'd4, 8'(8'hA1 + i * 13));
        wr(3'd0, 8'h7F);
        rd(3'd0, v); check("R11 empty bit with 8", v[4], 0); check("R11 half bit with 8", v[5], 1);
        wr(3'd4, 8'(8'hA1 + 8 * 13));
        wr(3'd0, 8'h7F);
        rd(3'd0, v); check("R11 half bit with 9", v[5], 0);
        bus_start();
        put_byte({OWN, 1'b1}, ack); check("R2 read address ack", ack, 1);
        for (int i = 0; i < 9; i++) begin
            get_byte(d, (i == 8) ? 1'b1 : 1'b0);
            check("R8 sent byte", d, 8'(8'hA1 + i * 13));
        end
        bus_stop();
        rd(3'd0, v);
        check("R10 master nack", v[6], 1);
        check("R11 empty after drain", v[4], 1);
        check("R11 half after drain", v[5], 1);
        check("R7 end after read", v[1], 1);

        // R9: clock stretch on empty queue
        wr(3'd0, 8'h7F);
        fork
            begin
                bus_start();
                put_byte({OWN, 1'b1}, ack);
                get_byte(d, 1'b1);
                bus_stop();
            end
            begin
                wait (scl_drv_n == 1'b0);
                tick(40);
                check("R9 clock held", scl_line, 0);
                wr(3'd4, 8'hC3);
            end
        join
        check("R9 byte after stretch", d, 8'hC3);
        rd(3'd0, v); check("R10 nack after stretch", v[6], 1);

        // R12: enables and write-one-to-clear
        wr(3'd1, 8'h02); tick(2);
        check("R12 irq from end bit", irq, 1);
        wr(3'd0, 8'h02); tick(2);
        check("R12 irq after clear", irq, 0);
        rd(3'd0, v); check("R12 bit cleared", v[1], 0);
        wr(3'd1, 8'h10); tick(2);
        check("R12 irq from empty", irq, 1);
        wr(3'd0, 8'h10); tick(2);
        check("R12 level re-sets", irq, 1);
        wr(3'd1, 8'h00); tick(2);
        check("R12 masked", irq, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule